// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It takes an enable pulse at sixteen times the bit rate. On each pulse it looks at a synchronised copy of the line, finds the falling edge that opens a character and confirms it half a bit later. It then samples every following bit in the middle of its period. It collects 5, 6, 7 or 8 data bits, least significant first. An optional parity bit can follow, checked for odd or even sense, and then the stop bit, which is checked as well.

At the end of every character the block presents the data and two error indications for exactly one clock cycle. It also raises a write strobe meant for a receive FIFO that sits outside it. A drop control can hold back the write strobe for characters that arrived damaged. Two further inputs choose the source and the sense of the serial line. One picks between the external pin and a loopback input fed by a local transmitter. The other inverts the chosen line before it is sampled. The FIFO, the bit-rate generator and every kind of interrupt or timeout logic stay outside the block.

Top module: `uart_frame_rx`

## Requirements
- R1: With `rxd_invert` high, the chosen line is inverted before the synchroniser. A low pin level then reads as logic 1 (idle), and characters sent with inverted levels are received intact.
- R2: With `loop_sel` high, characters are taken from `loop_rxd` and activity on `rxd_pin` has no effect. With it low, the roles of the two inputs swap.
- R3: A character begins when the synchronised line is seen low at a tick after having been high at the previous tick. It is accepted only if the line is still low at the 8th tick after that one. Otherwise the receiver goes back to idle and emits nothing.
- R4: `len_code` selects the number of data bits: 0 = 5, 1 = 6, 2 = 7, 3 = 8. The first data bit received lands in `fifo_data[0]`, and the `fifo_data` bits above the selected length are 0.
- R5: When `parity_en` is high, one parity bit follows the data. `parity_odd` = 0 expects an even count of ones over data and parity, and `parity_odd` = 1 expects an odd count. A mismatch raises `parity_err`. When `parity_en` is low, `parity_err` never rises.
- R6: A stop bit sampled low raises `frame_err`. A line that then stays low starts no new character until it has returned high.
- R7: When `drop_bad` is high, a character carrying a parity or framing error produces no `fifo_wr`. When it is low, the character is written anyway. The error outputs pulse in both cases.
- R8: `fifo_wr`, `parity_err` and `frame_err` are high for a single clock, in the clock after the tick that lies 24 + 16·(data bits + parity bits) ticks after the first tick with the line low. At every other time they are low, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock enable at 16x the bit rate |
| rxd_pin | input | 1 | External serial line |
| loop_rxd | input | 1 | Serial line from a local transmitter |
| loop_sel | input | 1 | 1 selects `loop_rxd`, 0 selects `rxd_pin` |
| rxd_invert | input | 1 | Invert the chosen line before sampling |
| len_code | input | 2 | Data length code (0..3 = 5..8 bits) |
| parity_en | input | 1 | Expect and check a parity bit |
| parity_odd | input | 1 | 0 even, 1 odd parity |
| drop_bad | input | 1 | Suppress the write of damaged characters |
| fifo_wr | output | 1 | One-cycle write strobe for the receive FIFO |
| fifo_data | output | 8 | Received character, zero-filled above its length |
| parity_err | output | 1 | One-cycle parity mismatch flag |
| frame_err | output | 1 | One-cycle low stop bit flag |

## Verification
Short low pulses are aimed at the start qualifier. A receiver that trusted the edge alone would emit a character of all ones with a framing error. Every length code is driven with all-ones data, and each parity sense is driven with good and with deliberately wrong parity bits, with the drop control both high and low. A wrong zero-fill, a wrong bit count or an inverted parity sense would show up as a wrong byte, a misplaced strobe or a spurious flag. A framing error followed by a long low line checks that the receiver does not start again on a level. Inverted and loopback traffic is sent while the unused input toggles, so that a source mux that leaked the unused input would corrupt the data.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DW     = 8;
    localparam int IDX_W  = $clog2(DW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       drop_bad;
    } rx_cfg_t;

    // index of the final data bit for a length code (5..8 bits)
    function automatic logic [IDX_W-1:0] last_index(logic [1:0] code);
        return IDX_W'(4) + IDX_W'(code);
    endfunction

    function automatic logic [DW-1:0] len_mask(logic [1:0] code);
        case (code)
            2'd0:    return 8'h1F;
            2'd1:    return 8'h3F;
            2'd2:    return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_pin,
    input  logic loop_rxd,
    input  logic loop_sel,
    input  logic rxd_invert,
    output logic line_s
);
    logic raw;
    logic [SYNC_STAGES-1:0] chain;

    assign raw = (loop_sel ? loop_rxd : rxd_pin) ^ rxd_invert;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign line_s = chain[SYNC_STAGES-1];

endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          line_s,
    input  rx_cfg_t       cfg_in,
    output logic          frame_end,
    output logic [DW-1:0] data_q,
    output logic          par_q,
    output logic          stop_bit,
    output rx_cfg_t       cfg_q
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    rx_state_e        state;
    logic [CW-1:0]    cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             last_q;
    logic             mid;

    assign mid       = (cnt == CW'(OSR - 1));
    assign frame_end = tick && (state == ST_STOP) && mid;
    assign stop_bit  = line_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            last_q  <= 1'b1;
            cfg_q   <= '0;
        end else if (tick) begin
            last_q <= line_s;
            case (state)
                ST_IDLE: begin
                    if (!line_s && last_q) begin
                        state <= ST_START;
                        cnt   <= '0;
                    end
                end
                ST_START: begin
                    if (cnt == CW'(HALF - 1)) begin
                        cnt <= '0;
                        if (!line_s) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                            data_q  <= '0;
                            cfg_q   <= cfg_in;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (mid) begin
                        cnt             <= '0;
                        data_q[bit_idx] <= line_s;
                        if (bit_idx == last_index(cfg_q.len))
                            state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (mid) begin
                        cnt   <= '0;
                        par_q <= line_s;
                        state <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (mid) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // entering the data phase needs a low line seen on a tick in the start phase
    assert_start_confirm_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_START) |-> $past(tick && !line_s));

    // the frame format stays fixed while a character is being assembled
    assert_cfg_held_R4: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_DATA, ST_PAR, ST_STOP} && $past(state) inside {ST_DATA, ST_PAR, ST_STOP})
        |-> $stable(cfg_q));

    // the parity phase is only visited when parity was enabled for this character
    assert_parity_phase_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAR) |-> cfg_q.par_en);

endmodule

// File: rtl/uart_rx_result.sv
module uart_rx_result
    import uart_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_end,
    input  logic [DW-1:0] data_in,
    input  logic          par_bit,
    input  logic          stop_bit,
    input  rx_cfg_t       cfg,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_data,
    output logic          parity_err,
    output logic          frame_err
);
    logic [DW-1:0] masked;
    logic          ones_odd;
    logic          pe;
    logic          fe;
    logic          keep;

    always_comb begin
        masked   = data_in & len_mask(cfg.len);
        ones_odd = (^masked) ^ par_bit;
        pe       = cfg.par_en && (ones_odd != cfg.par_odd);
        fe       = !stop_bit;
        keep     = !(cfg.drop_bad && (pe || fe));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr    <= 1'b0;
            fifo_data  <= '0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            fifo_wr    <= frame_end && keep;
            parity_err <= frame_end && pe;
            frame_err  <= frame_end && fe;
            if (frame_end) fifo_data <= masked;
        end
    end

    assert_drop_bad_R7: assert property (@(posedge clk) disable iff (rst)
        ((parity_err || frame_err) && cfg.drop_bad) |-> !fifo_wr);

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> !fifo_wr);

    assert_from_frame_end_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr || parity_err || frame_err) |-> $past(frame_end));

    assert_parity_gate_R5: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> cfg.par_en);

    assert_zero_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && cfg.len == 2'd0) |-> (fifo_data[DW-1:5] == '0));

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic          rxd_pin,
    input  logic          loop_rxd,
    input  logic          loop_sel,
    input  logic          rxd_invert,
    input  logic [1:0]    len_code,
    input  logic          parity_en,
    input  logic          parity_odd,
    input  logic          drop_bad,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_data,
    output logic          parity_err,
    output logic          frame_err
);
    logic          line_s;
    logic          frame_end;
    logic [DW-1:0] data_q;
    logic          par_q;
    logic          stop_bit;
    rx_cfg_t       cfg_in;
    rx_cfg_t       cfg_q;

    assign cfg_in = '{len: len_code, par_en: parity_en, par_odd: parity_odd, drop_bad: drop_bad};

    uart_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst        (rst),
        .rxd_pin    (rxd_pin),
        .loop_rxd   (loop_rxd),
        .loop_sel   (loop_sel),
        .rxd_invert (rxd_invert),
        .line_s     (line_s)
    );

    uart_rx_deframer #(.OSR(OSR)) u_deframer (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .line_s    (line_s),
        .cfg_in    (cfg_in),
        .frame_end (frame_end),
        .data_q    (data_q),
        .par_q     (par_q),
        .stop_bit  (stop_bit),
        .cfg_q     (cfg_q)
    );

    uart_rx_result u_result (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .data_in    (data_q),
        .par_bit    (par_q),
        .stop_bit   (stop_bit),
        .cfg        (cfg_q),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data),
        .parity_err (parity_err),
        .frame_err  (frame_err)
    );

endmodule

// File: tb/sim_uart_frame_rx.sv
module sim_uart_frame_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rxd_pin = 1'b1;
    logic       loop_rxd = 1'b1;
    logic       loop_sel = 1'b0;
    logic       rxd_invert = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       drop_bad = 1'b0;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       parity_err;
    logic       frame_err;

    uart_frame_rx u0 (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .rxd_pin    (rxd_pin),
        .loop_rxd   (loop_rxd),
        .loop_sel   (loop_sel),
        .rxd_invert (rxd_invert),
        .len_code   (len_code),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .drop_bad   (drop_bad),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data),
        .parity_err (parity_err),
        .frame_err  (frame_err)
    );

    always #5 clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    tick_idx = 0;
    int    exp_tick = -1;
    logic [7:0] exp_data = '0;
    logic  exp_wr = 1'b0;
    logic  exp_pe = 1'b0;
    logic  exp_fe = 1'b0;
    string exp_req = "R8";
    string quiet_req = "R8";
    logic  cur_line = 1'b1;
    logic  noise = 1'b0;
    logic  m_sel = 1'b0;
    logic  m_inv = 1'b0;
    bit    finished = 1'b0;

    task automatic drive_lines();
        logic phys;
        loop_sel   = m_sel;
        rxd_invert = m_inv;
        phys       = m_inv ? ~cur_line : cur_line;
        rxd_pin    = m_sel ? noise : phys;
        loop_rxd   = m_sel ? phys : noise;
    endtask

    task automatic check_outputs(bit pulse);
        logic ew, ep, ef;
        bit   bad;
        string req;
        ew  = pulse ? exp_wr : 1'b0;
        ep  = pulse ? exp_pe : 1'b0;
        ef  = pulse ? exp_fe : 1'b0;
        req = pulse ? exp_req : quiet_req;
        bad = (fifo_wr !== ew) || (parity_err !== ep) || (frame_err !== ef) ||
              (pulse && ew && (fifo_data !== exp_data));
        vectors++;
        if (bad) begin
            miscompares++;
            $display("FAIL %s tick %0d: wr/pe/fe/data = %b%b%b/%h, expected %b%b%b/%h",
                     req, tick_idx, fifo_wr, parity_err, frame_err, fifo_data,
                     ew, ep, ef, exp_data);
        end
    endtask

    // one baud tick period = 4 clocks; outputs compared at every negedge
    task automatic step_tick();
        @(negedge clk);
        check_outputs(1'b0);
        baud_tick = 1'b1;
        noise     = ~noise;
        drive_lines();
        @(negedge clk);
        baud_tick = 1'b0;
        check_outputs(tick_idx == exp_tick);
        @(negedge clk);
        check_outputs(1'b0);
        @(negedge clk);
        check_outputs(1'b0);
        tick_idx++;
    endtask

    task automatic hold(logic lvl, int n);
        cur_line = lvl;
        for (int i = 0; i < n; i++) step_tick();
    endtask

    task automatic send_frame(logic [7:0] val, logic [1:0] lc, logic pen, logic podd,
                              logic bad_par, logic stop_lvl, logic mask,
                              string req, int tail_low);
        int         nb;
        logic [7:0] d;
        logic       pbit;
        nb         = 5 + int'(lc);
        d          = val & 8'((16'd1 << nb) - 16'd1);
        len_code   = lc;
        parity_en  = pen;
        parity_odd = podd;
        drop_bad   = mask;
        exp_data   = d;
        exp_pe     = pen && bad_par;
        exp_fe     = !stop_lvl;
        exp_wr     = !(mask && (exp_pe || exp_fe));
        exp_req    = req;
        // first low tick is tick_idx+1; result lands 24 + 16*(bits) ticks later
        exp_tick   = tick_idx + 25 + 16 * (nb + (pen ? 1 : 0));
        hold(1'b0, 16);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (pen) begin
            pbit = (^d) ^ podd ^ bad_par;
            hold(pbit, 16);
        end
        hold(stop_lvl, 16);
        if (tail_low > 0) hold(1'b0, tail_low);
        hold(1'b1, 24);
        exp_tick = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired at tick %0d", tick_idx);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // reset state: all strobes low (R8)
        quiet_req = "R8 reset";
        hold(1'b1, 4);
        rst = 1'b0;
        hold(1'b1, 20);

        // basic 8-bit characters, LSB first (R4, R8)
        quiet_req = "R8";
        send_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 8-bit A5", 0);
        send_frame(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 8-bit 3C", 0);
        send_frame(8'h01, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 8-bit 01", 0);

        // shorter lengths, zero-filled above (R4)
        send_frame(8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 5-bit", 0);
        send_frame(8'hFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 6-bit", 0);
        send_frame(8'hFF, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 7-bit", 0);
        send_frame(8'h15, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R4 5-bit odd parity", 0);

        // parity senses, good and bad (R5, R7)
        send_frame(8'h96, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R5 even good", 0);
        send_frame(8'h97, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R5 odd good", 0);
        send_frame(8'h5E, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5 even bad kept R7", 0);
        send_frame(8'h21, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7 odd bad dropped", 0);
        send_frame(8'h44, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 parity disabled", 0);

        // framing errors, kept and dropped, then a held-low line (R6, R7)
        send_frame(8'h7E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 framing kept", 0);
        send_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 framing dropped", 0);
        quiet_req = "R6 low line after framing error";
        send_frame(8'h00, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 break", 48);
        send_frame(8'hC9, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 recovery", 0);

        // short low pulses rejected by start qualification (R3)
        quiet_req = "R3 glitch";
        hold(1'b0, 4);
        hold(1'b1, 30);
        hold(1'b0, 7);
        hold(1'b1, 30);
        send_frame(8'h6B, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 after glitch", 0);

        // inverted line levels (R1)
        quiet_req = "R1";
        m_inv = 1'b1;
        hold(1'b1, 8);
        send_frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 inverted", 0);
        send_frame(8'h13, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1 inverted parity", 0);

        // loopback source with the pin toggling (R2)
        quiet_req = "R2";
        m_inv = 1'b0;
        m_sel = 1'b1;
        hold(1'b1, 8);
        send_frame(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 loopback", 0);
        m_inv = 1'b1;
        hold(1'b1, 8);
        send_frame(8'h2D, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2 loopback inverted R1", 0);
        m_inv = 1'b0;
        m_sel = 1'b0;
        hold(1'b1, 8);
        send_frame(8'hE7, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 pin with loop toggling", 0);
        hold(1'b1, 8);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule